// File: doc/BRIEF.md
# SRAM DLL Start-Up Sequencer

This block sits on the controller side of a synchronous SRAM that contains a delay-locked loop. It takes the memory from power-on to a state where commands may safely be issued. It drives the pin that enables the memory's DLL, and it drives an enable that can gate the forwarded clock. It then counts clock cycles and raises two ready flags: one that permits writes and one that permits reads.

Two waits are enforced. The first is the DLL lock interval. It starts when the DLL is released, either by the enable pin rising or by the forwarded clock restarting after a deliberate stop. The second is a count of running clock cycles without reads, which lets the memory settle its output driver impedance. A strap selects between two board options: in the first, the sequencer drives the DLL enable pin; in the second, that pin is wired high on the board, and the DLL is reset by stopping the clock. When the configured clock frequency is below the DLL's operating floor, the sequencer leaves the DLL disabled and skips the lock wait.

A frequency-change request, a loss of clock stability or a loss of power-good sends the sequencer back to its start. Both waits are then run again from zero.

Top module: `sram_init_seq`

## Requirements
- R1: While `rst` is high or `pwr_good` is low, and one cycle after `pwr_good` falls, `dll_enable`=0, `clk_run`=1, `write_ready`=0 and `read_ready`=0.
- R2: While `clk_stable` is low, and one cycle after it falls, `dll_enable` and `write_ready` are 0, however long the wait lasts.
- R3: With `dll_pin_strapped`=0 and a DLL-capable frequency, `dll_enable` rises within STOP_CYCLES+2 cycles of power and clock both being good, and `clk_run` stays 1 throughout.
- R4: `write_ready` rises no earlier than LOCK_CYCLES cycles after the DLL is released, and no later than LOCK_CYCLES+2 cycles after.
- R5: With `dll_pin_strapped`=1, `clk_run` drops once power and clock are good, for between STOP_CYCLES and STOP_CYCLES+1 cycles, and is never 0 in the other strap setting.
- R6: With `dll_pin_strapped`=1, `write_ready` rises between LOCK_CYCLES and LOCK_CYCLES+2 cycles after `clk_run` returns to 1.
- R7: `read_ready` is 1 only when `write_ready` is 1 and at least ZQ_CYCLES running-clock cycles have passed since the sequencer left its start state.
- R8: When CLK_MHZ < DLL_MIN_MHZ, `dll_enable` stays 0 and `write_ready` rises one cycle after power and clock are good. `read_ready` follows ZQ_CYCLES to ZQ_CYCLES+1 cycles later.
- R9: A `freq_change` pulse clears both ready flags and `dll_enable` on the next cycle. The full stop and lock waits are then repeated before `write_ready` returns.
- R10: Dropping `pwr_good` during the lock wait aborts it. After power returns, a complete lock wait is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supplies are up and stable |
| clk_stable | input | 1 | Memory clock pair is running cleanly |
| freq_change | input | 1 | Pulse: operating frequency has changed |
| dll_pin_strapped | input | 1 | 1 = DLL enable pin tied high on the board, reset by clock stop |
| dll_enable | output | 1 | Drives the memory's DLL enable pin (1 = DLL on) |
| clk_run | output | 1 | 0 gates off the forwarded memory clock |
| write_ready | output | 1 | Controller may issue writes |
| read_ready | output | 1 | Controller may issue reads |

## Verification
The assertions assume that `dll_pin_strapped` is static between resets and that `freq_change` is a single-cycle pulse. They also assume that `clk_stable` is never high while `pwr_good` is low. The bench changes the strap only while `rst` is held, and raises `clk_stable` only after `pwr_good`. It issues frequency changes one cycle at a time, from the fully ready state. The check that the DLL enable never leaves 0 relies on the frequency parameter being fixed at elaboration, so that check uses a second instance built with a sub-floor frequency.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STOP = 2'd1,
    PH_LOCK = 2'd2,
    PH_RUN  = 2'd3
  } phase_t;
endpackage

// File: rtl/seq_cycle_counter.sv
module seq_cycle_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (en && (cnt_q != LAST))
      cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LAST);

  // R7
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !done);
endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import seq_pkg::*;
#(
  parameter bit BYPASS = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pwr_good,
  input  logic   clk_stable,
  input  logic   freq_change,
  input  logic   stop_done,
  input  logic   lock_done,
  output phase_t state_q,
  output phase_t state_d
);
  always_comb begin
    state_d = state_q;
    if (!pwr_good || !clk_stable) begin
      state_d = PH_IDLE;
    end else if (freq_change && (state_q != PH_IDLE)) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE: state_d = BYPASS ? PH_RUN : PH_STOP;
        PH_STOP: if (stop_done) state_d = PH_LOCK;
        PH_LOCK: if (lock_done) state_d = PH_RUN;
        PH_RUN:  state_d = PH_RUN;
        default: state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PH_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/sram_init_seq.sv
module sram_init_seq
  import seq_pkg::*;
#(
  parameter int CLK_MHZ     = 250,
  parameter int DLL_MIN_MHZ = 120,
  parameter int LOCK_CYCLES = 2048,
  parameter int ZQ_CYCLES   = 1024,
  parameter int STOP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic clk_stable,
  input  logic freq_change,
  input  logic dll_pin_strapped,
  output logic dll_enable,
  output logic clk_run,
  output logic write_ready,
  output logic read_ready
);
  localparam bit BYPASS = (CLK_MHZ < DLL_MIN_MHZ);

  phase_t state_q, state_d;
  logic   stop_done, lock_done, zq_done;
  logic   dll_q, run_q, wr_q;

  seq_phase_fsm #(.BYPASS(BYPASS)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pwr_good   (pwr_good),
    .clk_stable (clk_stable),
    .freq_change(freq_change),
    .stop_done  (stop_done),
    .lock_done  (lock_done),
    .state_q    (state_q),
    .state_d    (state_d)
  );

  seq_cycle_counter #(.LIMIT(STOP_CYCLES)) u_stop_cnt (
    .clk (clk),
    .rst (rst),
    .clr (state_q != PH_STOP),
    .en  (state_q == PH_STOP),
    .done(stop_done)
  );

  seq_cycle_counter #(.LIMIT(LOCK_CYCLES)) u_lock_cnt (
    .clk (clk),
    .rst (rst),
    .clr (state_q != PH_LOCK),
    .en  (state_q == PH_LOCK),
    .done(lock_done)
  );

  // Non-read cycles: only counted while the memory clock is running.
  seq_cycle_counter #(.LIMIT(ZQ_CYCLES)) u_zq_cnt (
    .clk (clk),
    .rst (rst),
    .clr (state_q == PH_IDLE),
    .en  (run_q),
    .done(zq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dll_q <= 1'b0;
      run_q <= 1'b1;
      wr_q  <= 1'b0;
    end else begin
      dll_q <= !BYPASS && ((state_d == PH_LOCK) || (state_d == PH_RUN));
      run_q <= !((state_d == PH_STOP) && dll_pin_strapped);
      wr_q  <= (state_d == PH_RUN);
    end
  end

  assign dll_enable  = dll_q;
  assign clk_run     = run_q;
  assign write_ready = wr_q;
  assign read_ready  = wr_q && zq_done;

  // R1
  pwr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (!dll_enable && clk_run && !write_ready && !read_ready));

  // R2
  unstable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_stable |=> (!dll_enable && !write_ready));

  // R4
  ready_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(write_ready) |-> (BYPASS || $past(lock_done)));

  // R5
  stop_only_strapped_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_run |-> (dll_pin_strapped && !dll_enable && !write_ready));

  // R7
  read_gate_chk: assert property (@(posedge clk) disable iff (rst)
    read_ready |-> write_ready);

  // R9
  freq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_change && write_ready) |=> (!write_ready && !read_ready && !dll_enable));

  generate
    if (BYPASS) begin : g_bypass_chk
      // R8
      bypass_off_chk: assert property (@(posedge clk) disable iff (rst)
        !dll_enable);
    end
  endgenerate
endmodule

// File: tb/test_sram_init_seq.sv
module test_sram_init_seq;
  localparam int LOCK = 2048;
  localparam int ZQ   = 1024;
  localparam int STOP = 4;

  logic clk = 1'b0;
  logic rst, pwr_good, clk_stable, freq_change, strap;
  logic dll_en, clk_run, wr_rdy, rd_rdy;
  logic b_dll_en, b_clk_run, b_wr_rdy, b_rd_rdy;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;

  sram_init_seq #(.LOCK_CYCLES(LOCK), .ZQ_CYCLES(ZQ), .STOP_CYCLES(STOP)) i_sram_init_seq (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .clk_stable(clk_stable),
    .freq_change(freq_change), .dll_pin_strapped(strap),
    .dll_enable(dll_en), .clk_run(clk_run), .write_ready(wr_rdy), .read_ready(rd_rdy)
  );

  sram_init_seq #(.CLK_MHZ(100), .LOCK_CYCLES(LOCK), .ZQ_CYCLES(ZQ), .STOP_CYCLES(STOP)) i_sram_init_seq_bypass (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .clk_stable(clk_stable),
    .freq_change(freq_change), .dll_pin_strapped(1'b0),
    .dll_enable(b_dll_en), .clk_run(b_clk_run), .write_ready(b_wr_rdy), .read_ready(b_rd_rdy)
  );

  task automatic check(input string req, input int act, input int exp_lo, input int exp_hi);
    n_checks++;
    if (act < exp_lo || act > exp_hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1; pwr_good = 1'b0; clk_stable = 1'b0; freq_change = 1'b0; strap = s;
    cycles(3);
    rst = 1'b0;
  endtask

  // Count negedges until wr_rdy is seen high (limit bounds it).
  task automatic wait_wr(output int n);
    n = 0;
    while (!wr_rdy && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    check("R1 reset dll_enable", dll_en, 0, 0);
    check("R1 reset clk_run", clk_run, 1, 1);
    check("R1 reset write_ready", wr_rdy, 0, 0);
    check("R1 reset read_ready", rd_rdy, 0, 0);
    cycles(20);
    check("R1 no power dll_enable", dll_en, 0, 0);
    check("R1 no power write_ready", wr_rdy, 0, 0);
  endtask

  task automatic t_unstable_clock();
    int bad;
    do_reset(1'b0);
    pwr_good = 1'b1;
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (dll_en || wr_rdy || b_wr_rdy) bad++;
    end
    check("R2 outputs idle while clock unstable", bad, 0, 0);
  endtask

  task automatic t_driven_lock();
    int n, lowrun;
    do_reset(1'b0);
    pwr_good = 1'b1;
    cycles(2);
    clk_stable = 1'b1;
    n = 0; lowrun = 0;
    while (!dll_en && n < 50) begin @(negedge clk); n++; if (!clk_run) lowrun++; end
    check("R3 dll_enable rise delay", n, 1, STOP + 2);
    check("R3 clock never stopped", lowrun, 0, 0);
    check("R3 not ready at release", wr_rdy, 0, 0);
    wait_wr(n);
    check("R4 lock wait after dll release", n, LOCK, LOCK + 2);
    check("R7 read ready with write ready (zq done)", rd_rdy, 1, 1);
  endtask

  task automatic t_freq_change();
    int n;
    @(negedge clk);
    freq_change = 1'b1;
    @(negedge clk);
    freq_change = 1'b0;
    check("R9 write_ready cleared", wr_rdy, 0, 0);
    check("R9 read_ready cleared", rd_rdy, 0, 0);
    check("R9 dll_enable cleared", dll_en, 0, 0);
    n = 0;
    while (!dll_en && n < 50) begin @(negedge clk); n++; end
    check("R9 dll re-released", n, 1, STOP + 2);
    wait_wr(n);
    check("R9 full relock wait", n, LOCK, LOCK + 2);
  endtask

  task automatic t_strapped();
    int n, low;
    do_reset(1'b1);
    pwr_good = 1'b1;
    clk_stable = 1'b1;
    n = 0;
    while (clk_run && n < 50) begin @(negedge clk); n++; end
    check("R5 clock stop begins", n, 1, 3);
    low = 0;
    while (!clk_run && low < 100) begin @(negedge clk); low++; end
    check("R5 clock stop length", low, STOP, STOP + 1);
    wait_wr(n);
    check("R6 lock wait after clock restart", n, LOCK, LOCK + 2);
    check("R7 read ready after strapped lock", rd_rdy, 1, 1);
  endtask

  task automatic t_power_abort();
    int n;
    do_reset(1'b0);
    pwr_good = 1'b1;
    clk_stable = 1'b1;
    cycles(1000);
    check("R10 mid-lock not ready", wr_rdy, 0, 0);
    pwr_good = 1'b0;
    clk_stable = 1'b0;
    @(negedge clk);
    check("R10 power drop clears dll_enable", dll_en, 0, 0);
    check("R1 power drop keeps clock running", clk_run, 1, 1);
    cycles(5);
    pwr_good = 1'b1;
    clk_stable = 1'b1;
    n = 0;
    while (!dll_en && n < 50) begin @(negedge clk); n++; end
    wait_wr(n);
    check("R10 full lock after power return", n, LOCK, LOCK + 2);
  endtask

  task automatic t_bypass();
    int n, on, gap;
    do_reset(1'b0);
    pwr_good = 1'b1;
    clk_stable = 1'b1;
    n = 0; on = 0;
    while (!b_wr_rdy && n < 50) begin @(negedge clk); n++; if (b_dll_en) on++; end
    check("R8 write ready without lock wait", n, 1, 1);
    check("R8 read not yet ready", b_rd_rdy, 0, 0);
    gap = 0;
    while (!b_rd_rdy && gap < 3000) begin @(negedge clk); gap++; if (b_dll_en) on++; end
    check("R7 R8 read ready after zq count", gap, ZQ, ZQ + 1);
    check("R8 dll never enabled", on, 0, 0);
    check("R5 clock never stopped in bypass", b_clk_run, 1, 1);
  endtask

  initial begin
    rst = 1'b1; pwr_good = 1'b0; clk_stable = 1'b0; freq_change = 1'b0; strap = 1'b0;
    t_reset_state();
    t_unstable_clock();
    t_driven_lock();
    t_freq_change();
    t_strapped();
    t_power_abort();
    t_bypass();
    finish_run();
  end
endmodule